// File: doc/BRIEF.md
# Step and Direction Pulse Generator

This block turns a move command into a train of step pulses and a direction level for a motor drive that advances one increment per pulse. A host writes a signed move word. Its top bit selects the direction of travel, and its remaining bits give the number of steps to issue. A separately loaded rate word sets the step frequency.

The rate word is summed every cycle into a wrapping phase accumulator. Each wrap of that accumulator, seen as a falling edge of its top bit, allows one step. A step counter running on the system clock tallies the issued steps and halts the train when the tally reaches the requested magnitude. There is one clock and no derived clock: the step signal only acts as an enable inside the block.

Top module: `step_dir_gen`

## Requirements
- R1: `cmd_in` is captured only on a cycle with `cmd_wr` high. `dir_o` then takes `cmd_in[CMD_W-1]` one cycle after the write, and it does not change at any other time, whatever happens on `cmd_in`.
- R2: The step count is `cmd_in[CMD_W-2:0]`, read as unsigned. Exactly that many step pulses follow a write. A count of zero produces no pulse and leaves `busy_o` low.
- R3: `RATE_W` is W and the loaded rate word is R, with 1 <= R <= 2^(W-1). Count the write clock edge as edge 0. Step n (n = 1, 2, ...) is high in the cycle just after edge ceil(n*2^W/R)+1. Every step pulse lasts exactly one clock cycle.
- R4: The rate register takes `rate_in` only on a cycle with `rate_ld` high. At other times, changes on `rate_in` have no effect on step timing.
- R5: `busy_o` is high from the cycle after an accepted nonzero write through the cycle in which the final step is high, and it is low afterwards.
- R6: Loading a rate of zero during a move stops the steps while `busy_o` stays high. The steps already issued are kept, so after a nonzero rate is reloaded, the move completes with the originally requested total.
- R7: A write during a move restarts the block. The accumulator and the step tally are cleared, no step is issued in the cycle after the write, and timing follows R3 from the new write. `dir_o` is valid at least one cycle before the first new step.
- R8: After reset, `step_o`, `busy_o` and `dir_o` are low and the rate register is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Write strobe for the move command |
| cmd_in | input | CMD_W | Move command: top bit is direction, lower bits are step count |
| rate_ld | input | 1 | Load strobe for the rate word |
| rate_in | input | RATE_W | Phase increment added per clock cycle |
| step_o | output | 1 | One-cycle step pulse |
| dir_o | output | 1 | Direction level |
| busy_o | output | 1 | High while a move is in progress |

## Verification
There are three registers between a write and the first possible step: the accumulator, its top-bit copy, and the registered step output. Step n is therefore due in the cycle after edge ceil(n*2^W/R)+1, counting the write edge as edge 0. `busy_o` is due low two edges after the final wrap, and `dir_o` is due one edge after the write. The bench drives inputs on falling edges and counts rising edges from the write. After every edge it compares `step_o`, `busy_o` and `dir_o` with values computed from that formula. It sweeps every rate from 1 to half scale against several step counts, and it scrambles `cmd_in` and `rate_in` between strobes to show that they are ignored.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
    localparam int unsigned SDG_CMD_W_DEF  = 32;
    localparam int unsigned SDG_RATE_W_DEF = 32;

    // A wrap of the accumulator shows up as its top bit falling.
    function automatic logic sdg_msb_fell(input logic prev_msb, input logic cur_msb);
        return prev_msb & ~cur_msb;
    endfunction
endpackage

// File: rtl/sdg_phase_acc.sv
module sdg_phase_acc #(
    parameter int unsigned RATE_W = sdg_pkg::SDG_RATE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              rate_ld,
    input  logic [RATE_W-1:0] rate_in,
    output logic              wrap_o
);
    localparam int unsigned TOP = RATE_W - 1;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [RATE_W-1:0] acc;
        logic              prev_msb;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rate_ld) begin
            st_d.rate = rate_in;
        end
        if (clr) begin
            st_d.acc      = '0;
            st_d.prev_msb = 1'b0;
        end else if (run) begin
            st_d.acc      = st_q.acc + st_q.rate;
            st_d.prev_msb = st_q.acc[TOP];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap_o = sdg_pkg::sdg_msb_fell(st_q.prev_msb, st_q.acc[TOP]);
endmodule

// File: rtl/sdg_pulse_cnt.sv
module sdg_pulse_cnt #(
    parameter int unsigned MAG_W = sdg_pkg::SDG_CMD_W_DEF - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [MAG_W-1:0] target_in,
    input  logic             wrap,
    output logic             active_o,
    output logic             step_o
);
    typedef struct packed {
        logic [MAG_W-1:0] target;
        logic [MAG_W-1:0] tally;
        logic             active;
        logic             step;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       fire;
    logic [MAG_W-1:0] tally_inc;

    assign fire      = wrap & st_q.active;
    assign tally_inc = st_q.tally + 1'b1;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.target = target_in;
            st_d.tally  = '0;
            st_d.active = (target_in != '0);
            st_d.step   = 1'b0;
        end else begin
            st_d.step = fire;
            if (fire) begin
                st_d.tally = tally_inc;
                if (tally_inc == st_q.target) begin
                    st_d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign step_o   = st_q.step;
endmodule

// File: rtl/step_dir_gen.sv
module step_dir_gen #(
    parameter int unsigned CMD_W  = sdg_pkg::SDG_CMD_W_DEF,
    parameter int unsigned RATE_W = sdg_pkg::SDG_RATE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_in,
    input  logic              rate_ld,
    input  logic [RATE_W-1:0] rate_in,
    output logic              step_o,
    output logic              dir_o,
    output logic              busy_o
);
    localparam int unsigned MAG_W = CMD_W - 1;

    typedef struct packed {
        logic dir;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       wrap;
    logic       active;
    logic       step;

    always_comb begin
        st_d = st_q;
        if (cmd_wr) begin
            st_d.dir = cmd_in[CMD_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sdg_phase_acc #(.RATE_W(RATE_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cmd_wr),
        .run     (active),
        .rate_ld (rate_ld),
        .rate_in (rate_in),
        .wrap_o  (wrap)
    );

    sdg_pulse_cnt #(.MAG_W(MAG_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cmd_wr),
        .target_in (cmd_in[MAG_W-1:0]),
        .wrap      (wrap),
        .active_o  (active),
        .step_o    (step)
    );

    assign step_o = step;
    assign dir_o  = st_q.dir;
    assign busy_o = active | step;
endmodule

// File: rtl/sdg_checker.sv
module sdg_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_wr,
    input logic step_o,
    input logic dir_o,
    input logic busy_o
);
    // R3: a step never lasts longer than one cycle
    p_step_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);

    // R5: a step is only seen while the move is in progress
    p_step_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> busy_o);

    // R1: direction moves only after a write
    p_dir_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(dir_o));

    // R7: the cycle after a write never carries a step
    p_no_step_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !step_o);

    // R2: an idle block stays idle until written
    p_idle_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !cmd_wr) |=> (!busy_o && !step_o));
endmodule

bind step_dir_gen sdg_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_wr (cmd_wr),
    .step_o (step_o),
    .dir_o  (dir_o),
    .busy_o (busy_o)
);

// File: tb/step_dir_gen_tb.sv
module step_dir_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int RW = 6;
    localparam int FULL = 1 << RW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [CW-1:0] cmd_in = '0;
    logic          rate_ld = 1'b0;
    logic [RW-1:0] rate_in = '0;
    logic          step_o, dir_o, busy_o;

    int n_cmp = 0;
    int n_bad = 0;

    step_dir_gen #(.CMD_W(CW), .RATE_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_in(cmd_in),
        .rate_ld(rate_ld), .rate_in(rate_in),
        .step_o(step_o), .dir_o(dir_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
        end
    endtask

    function automatic int due(input int n, input int r);
        return (n * FULL + r - 1) / r + 1;
    endfunction

    task automatic load_rate(input int r);
        @(negedge clk);
        rate_in = RW'(r);
        rate_ld = 1'b1;
        @(negedge clk);
        rate_ld = 1'b0;
        rate_in = ~RW'(r);  // R4: scrambled bus without a strobe
    endtask

    task automatic write_cmd(input logic d, input int mag);
        @(negedge clk);
        cmd_in = {d, 7'(mag)};
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        cmd_in = ~{d, 7'(mag)};  // R1: bus changes without a strobe
    endtask

    // Write and then check every cycle against the R3 timing formula
    task automatic run_check(input logic d, input int mag, input int r);
        int nxt = 1;
        int last = (mag > 0) ? due(mag, r) : 0;
        int ncyc = (mag > 0) ? last + 3 : 2 * FULL / r + 4;
        logic es, eb;
        write_cmd(d, mag);
        chk(step_o, 1'b0, "R7");
        chk(busy_o, 1'(mag > 0), "R2/R5");
        chk(dir_o, d, "R1");
        for (int i = 1; i <= ncyc; i++) begin
            @(negedge clk);
            es = 1'b0;
            if (nxt <= mag && i == due(nxt, r)) begin
                es = 1'b1;
                nxt++;
            end
            eb = 1'(mag > 0 && i <= last);
            chk(step_o, es, "R3");
            chk(busy_o, eb, "R5");
            chk(dir_o, d, "R1");
        end
        chk(1'(nxt == mag + 1), 1'b1, "R2");
    endtask

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int mags[5] = '{0, 1, 2, 5, 127};
        int cnt;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(step_o, 1'b0, "R8");
        chk(busy_o, 1'b0, "R8");
        chk(dir_o, 1'b0, "R8");
        rst_n = 1'b1;
        // R8: rate register is zero after reset, so a move does not advance
        write_cmd(1'b1, 3);
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            cnt += int'(step_o);
        end
        chk(1'(cnt == 0), 1'b1, "R8");
        chk(busy_o, 1'b1, "R8");

        // R2 R3 R4 R5: sweep of every usable rate and several counts
        for (int r = 1; r <= FULL / 2; r++) begin
            load_rate(r);
            foreach (mags[m]) run_check(1'((r + m) & 1), mags[m], r);
        end

        // R7: restart in the middle of a move
        load_rate(8);
        write_cmd(1'b0, 10);
        repeat (20) @(negedge clk);
        run_check(1'b1, 3, 8);
        load_rate(32);
        write_cmd(1'b1, 20);
        repeat (7) @(negedge clk);
        run_check(1'b0, 4, 32);

        // R6: zero rate stalls, and the tally survives
        load_rate(16);
        write_cmd(1'b1, 5);
        cnt = 0;
        while (cnt == 0) begin
            @(negedge clk);
            cnt += int'(step_o);
        end
        load_rate(0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cnt += int'(step_o);
        end
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            chk(step_o, 1'b0, "R6");
            chk(busy_o, 1'b1, "R6");
        end
        load_rate(16);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            cnt += int'(step_o);
        end
        chk(1'(cnt == 5), 1'b1, "R6");
        chk(busy_o, 1'b0, "R6");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule